// File: doc/BRIEF.md
# Selectable-Source Timer with Clear Control

This block is a 16-bit up-counter. A control register chooses what advances it: the system clock, one of four divided rates from a free-running prescaler, or one of two external clock pins. For a pin source, the register also chooses rising, falling or both-edge counting. Both pins go through a two-flop synchronizer, and every qualifying edge becomes a single-cycle count enable inside the system clock domain. No derived clock is used.

Two general registers, A and B, sit beside the counter. Each one works either as a compare value, which raises a match pulse when the counter reaches it, or as a capture target, which latches the counter on a rising edge of its own capture input. The control register can choose a match or capture on A or on B to return the counter to zero in place of the next increment. The control register is locked while the start bit is high. A phase-count mode input stops normal counting.

Top module: `cnt_src_timer`

## Requirements
- R1: After reset the counter, both general registers, the control register, the mode bits and all four flag outputs are zero.
- R2: A write to the control register (wr_sel 0) takes effect only while run is 0. A write made while run is 1 is ignored and the previous configuration stays in force.
- R3: The source field, control bits [2:0], gives one count per clock for 000, one per 2 clocks for 001, one per 4 for 010, one per 8 for 011 and one per 32 for 100. For these sources the edge field has no effect.
- R4: Source 101 counts edges of ext_clk0 and source 111 counts edges of ext_clk1. The edge field, control bits [4:3], selects rising edges for 00, falling edges for 01 and both edges for 10. A pin change made between clock edges shows on the counter after the third rising clock edge.
- R5: The reserved source value 110 and the reserved edge value 11 (with a pin source) produce no counting. The reserved clear value 11 never clears the counter.
- R6: While phase_mode is 1 the counter does not advance, whatever the configuration.
- R7: While run is 0 the counter holds its value.
- R8: The clear field, control bits [6:5], never clears for 00. For 01 it clears on a register A event and for 10 on a register B event. On a count enable that coincides with the selected event, the counter becomes 0 instead of incrementing.
- R9: wr_sel 1 writes register A, wr_sel 2 writes register B, and wr_sel 3 writes the mode bits (bit 0 puts A in capture mode, bit 1 puts B in capture mode; 0 means compare). In compare mode, a count enable while the counter equals the register raises that register's match pulse for one cycle.
- R10: In capture mode, a rising edge on the capture input loads the register with the counter value present just before the third clock edge after the input rises, and raises the capture pulse for one cycle. A falling edge does nothing, and in compare mode the capture input is ignored.
- R11: Without a clear, the counter wraps from 0xFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start bit: counts while 1, holds while 0 |
| phase_mode | input | 1 | Phase-count mode: suppresses normal counting |
| ext_clk0 | input | 1 | External clock pin 0 (asynchronous) |
| ext_clk1 | input | 1 | External clock pin 1 (asynchronous) |
| cap_a | input | 1 | Capture input for register A |
| cap_b | input | 1 | Capture input for register B |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 A, 2 B, 3 modes |
| wr_data | input | 16 | Write data |
| tmr_cnt | output | 16 | Counter value |
| gen_a | output | 16 | General register A |
| gen_b | output | 16 | General register B |
| cmp_hit_a | output | 1 | Compare match pulse, register A |
| cmp_hit_b | output | 1 | Compare match pulse, register B |
| cap_hit_a | output | 1 | Capture pulse, register A |
| cap_hit_b | output | 1 | Capture pulse, register B |

## Verification
An internal-source count changes the counter at the same clock edge that sees the enable. The match pulse rises at that edge too, so rate checks run whole multiples of 32 clocks and compare counter deltas after the run bit is dropped. Pin edges and capture edges take three clock edges to reach the counter or the register. The bench checks that the counter has not moved after two edges and has moved after the third, and it holds run high for several cycles after the last pin toggle so that no edge is still in the pipeline. Pulse outputs are counted by a monitor on the falling clock edge, and the pulse totals are compared with the number of wraps worked out from the run length and the compare value.

// File: rtl/cnt_src_timer.sv
module cnt_src_timer #(
  parameter int CW = 16,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          phase_mode,
  input  logic          ext_clk0,
  input  logic          ext_clk1,
  input  logic          cap_a,
  input  logic          cap_b,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] tmr_cnt,
  output logic [CW-1:0] gen_a,
  output logic [CW-1:0] gen_b,
  output logic          cmp_hit_a,
  output logic          cmp_hit_b,
  output logic          cap_hit_a,
  output logic          cap_hit_b
);

  localparam int SW = 3;

  logic [7:0]    ctrl_q;
  logic [1:0]    mode_q;
  logic [PW-1:0] div_q;
  logic [SW-1:0] e0_s, e1_s, ca_s, cb_s;

  logic [2:0] src_f;
  logic [1:0] edg_f, clr_f;
  assign src_f = ctrl_q[2:0];
  assign edg_f = ctrl_q[4:3];
  assign clr_f = ctrl_q[6:5];

  function automatic logic pin_hit(input logic [SW-1:0] s, input logic [1:0] e);
    logic r, f;
    r = s[1] & ~s[2];
    f = ~s[1] & s[2];
    case (e)
      2'b00:   pin_hit = r;
      2'b01:   pin_hit = f;
      2'b10:   pin_hit = r | f;
      default: pin_hit = 1'b0;
    endcase
  endfunction

  logic src_tick;
  always_comb begin
    case (src_f)
      3'b000:  src_tick = 1'b1;
      3'b001:  src_tick = &div_q[0:0];
      3'b010:  src_tick = &div_q[1:0];
      3'b011:  src_tick = &div_q[2:0];
      3'b100:  src_tick = &div_q[4:0];
      3'b101:  src_tick = pin_hit(e0_s, edg_f);
      3'b111:  src_tick = pin_hit(e1_s, edg_f);
      default: src_tick = 1'b0;
    endcase
  end

  logic tick, cap_a_edge, cap_b_edge, ev_a, ev_b, clr_now;
  assign tick       = run & ~phase_mode & src_tick;
  assign cap_a_edge = ca_s[1] & ~ca_s[2];
  assign cap_b_edge = cb_s[1] & ~cb_s[2];
  assign ev_a = mode_q[0] ? cap_a_edge : (tmr_cnt == gen_a);
  assign ev_b = mode_q[1] ? cap_b_edge : (tmr_cnt == gen_b);
  assign clr_now = tick & (((clr_f == 2'b01) & ev_a) | ((clr_f == 2'b10) & ev_b));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      e0_s  <= '0;
      e1_s  <= '0;
      ca_s  <= '0;
      cb_s  <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      e0_s  <= {e0_s[SW-2:0], ext_clk0};
      e1_s  <= {e1_s[SW-2:0], ext_clk1};
      ca_s  <= {ca_s[SW-2:0], cap_a};
      cb_s  <= {cb_s[SW-2:0], cap_b};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == 2'd0 && !run) ctrl_q <= wr_data[7:0];
      if (wr_sel == 2'd3) mode_q <= wr_data[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_cnt <= '0;
    else if (tick) tmr_cnt <= clr_now ? '0 : tmr_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_a     <= '0;
      gen_b     <= '0;
      cmp_hit_a <= 1'b0;
      cmp_hit_b <= 1'b0;
      cap_hit_a <= 1'b0;
      cap_hit_b <= 1'b0;
    end else begin
      cmp_hit_a <= tick & ~mode_q[0] & (tmr_cnt == gen_a);
      cmp_hit_b <= tick & ~mode_q[1] & (tmr_cnt == gen_b);
      cap_hit_a <= mode_q[0] & cap_a_edge;
      cap_hit_b <= mode_q[1] & cap_b_edge;
      if (mode_q[0] && cap_a_edge) gen_a <= tmr_cnt;
      else if (wr_en && wr_sel == 2'd1) gen_a <= wr_data;
      if (mode_q[1] && cap_b_edge) gen_b <= tmr_cnt;
      else if (wr_en && wr_sel == 2'd2) gen_b <= wr_data;
    end
  end

  a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(ctrl_q));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(tmr_cnt));
  a_r6_phase_stops: assert property (@(posedge clk) disable iff (!rst_n)
    phase_mode |=> $stable(tmr_cnt));
  a_r5_reserved_src: assert property (@(posedge clk) disable iff (!rst_n)
    (src_f == 3'b110) |=> $stable(tmr_cnt));
  a_r8_clear_on_a: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_f == 2'b01 && cmp_hit_a) |-> (tmr_cnt == '0));
  a_r10_cap_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit_a |-> $past(mode_q[0]));
  a_r11_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_cnt != $past(tmr_cnt)) |-> (tmr_cnt == CW'($past(tmr_cnt) + 1'b1) || tmr_cnt == '0));

endmodule

// File: tb/sim_cnt_src_timer.sv
`timescale 1ns/1ps
module sim_cnt_src_timer;
  logic clk = 0, rst_n = 0, run = 0, phase_mode = 0;
  logic ext_clk0 = 0, ext_clk1 = 0, cap_a = 0, cap_b = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] tmr_cnt, gen_a, gen_b;
  logic cmp_hit_a, cmp_hit_b, cap_hit_a, cap_hit_b;

  int checks = 0, fails = 0, na = 0, nb = 0, ca = 0;
  bit done = 0;
  logic [15:0] base;

  always #2 clk = ~clk;

  cnt_src_timer u0 (.clk(clk), .rst_n(rst_n), .run(run), .phase_mode(phase_mode),
    .ext_clk0(ext_clk0), .ext_clk1(ext_clk1), .cap_a(cap_a), .cap_b(cap_b),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .tmr_cnt(tmr_cnt),
    .gen_a(gen_a), .gen_b(gen_b), .cmp_hit_a(cmp_hit_a), .cmp_hit_b(cmp_hit_b),
    .cap_hit_a(cap_hit_a), .cap_hit_b(cap_hit_b));

  always @(negedge clk) begin
    na += int'(cmp_hit_a);
    nb += int'(cmp_hit_b);
    ca += int'(cap_hit_a);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; run = 0; phase_mode = 0; ext_clk0 = 0; ext_clk1 = 0;
    cap_a = 0; cap_b = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run_for(input int n);
    run = 1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    run = 0;
  endtask

  task automatic pin_pulses(input int pin, input int n);
    run = 1;
    for (int i = 0; i < n; i++) begin
      if (pin == 0) ext_clk0 = 1; else ext_clk1 = 1;
      repeat (4) @(negedge clk);
      if (pin == 0) ext_clk0 = 0; else ext_clk1 = 0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    run = 0;
  endtask

  initial begin
    do_reset();
    chk("R1 count", tmr_cnt, 0);
    chk("R1 regs", int'(gen_a) + int'(gen_b), 0);
    chk("R1 flags", cmp_hit_a + cmp_hit_b + cap_hit_a + cap_hit_b, 0);

    for (int s = 0; s < 5; s++) begin
      int dv;
      dv = (s == 4) ? 32 : (1 << s);
      wr(0, 16'(s));
      base = tmr_cnt;
      run_for(64);
      chk($sformatf("R3 rate src%0d", s), 16'(tmr_cnt - base), 64 / dv);
    end
    wr(0, 16'h19);
    base = tmr_cnt; run_for(64);
    chk("R3 edge field ignored internal", 16'(tmr_cnt - base), 32);

    wr(0, 16'h06);
    base = tmr_cnt; run_for(64);
    chk("R5 reserved source", 16'(tmr_cnt - base), 0);

    wr(0, 16'h00); phase_mode = 1;
    base = tmr_cnt; run_for(64);
    chk("R6 phase mode", 16'(tmr_cnt - base), 0);
    phase_mode = 0;

    base = tmr_cnt; repeat (20) @(negedge clk);
    chk("R7 hold while stopped", 16'(tmr_cnt - base), 0);

    for (int p = 0; p < 2; p++)
      for (int e = 0; e < 4; e++) begin
        int ex;
        ex = (e == 2) ? 10 : (e == 3) ? 0 : 5;
        wr(0, 16'((e << 3) | (p ? 7 : 5)));
        base = tmr_cnt;
        pin_pulses(p, 5);
        chk($sformatf("R4 pin%0d edge%0d", p, e), 16'(tmr_cnt - base), ex);
      end
    wr(0, 16'h05);
    base = tmr_cnt; pin_pulses(1, 5);
    chk("R4 unselected pin ignored", 16'(tmr_cnt - base), 0);

    base = tmr_cnt;
    run = 1; ext_clk0 = 1;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R4 latency not before third edge", 16'(tmr_cnt - base), 0);
    @(posedge clk); @(negedge clk);
    chk("R4 latency third edge", 16'(tmr_cnt - base), 1);
    run = 0; ext_clk0 = 0; repeat (4) @(negedge clk);

    do_reset();
    wr(0, 16'h04);
    run = 1;
    wr(0, 16'h00);
    repeat (63) @(posedge clk);
    @(negedge clk); run = 0;
    chk("R2 write ignored while running", tmr_cnt, 2);

    do_reset();
    wr(1, 16'd9); wr(0, 16'h20);
    na = 0; run_for(25);
    chk("R8 clear on A count", tmr_cnt, 5);
    chk("R9 match A pulses", na, 2);

    do_reset();
    wr(2, 16'd4); wr(0, 16'h40);
    nb = 0; run_for(23);
    chk("R8 clear on B count", tmr_cnt, 3);
    chk("R9 match B pulses", nb, 4);

    do_reset();
    wr(1, 16'd2); wr(0, 16'h60);
    run_for(10);
    chk("R5 reserved clear", tmr_cnt, 10);

    do_reset();
    wr(3, 16'd1); wr(0, 16'h20);
    ca = 0;
    run = 1; cap_a = 1;
    repeat (3) @(posedge clk); @(negedge clk);
    run = 0;
    chk("R10 capture value A", gen_a, 2);
    chk("R10 capture pulse A", cap_hit_a, 1);
    chk("R8 clear on A capture", tmr_cnt, 0);
    cap_a = 0; repeat (6) @(negedge clk);
    chk("R10 falling edge no capture", ca, 1);
    chk("R10 value kept", gen_a, 2);

    do_reset();
    wr(3, 16'd2); wr(0, 16'h00);
    run = 1; cap_b = 1;
    repeat (3) @(posedge clk); @(negedge clk);
    run = 0;
    chk("R10 capture value B", gen_b, 2);
    chk("R10 no clear selected", tmr_cnt, 3);
    cap_b = 0;
    ca = 0; cap_a = 1; repeat (6) @(negedge clk); cap_a = 0; repeat (4) @(negedge clk);
    chk("R10 compare mode ignores capture input", gen_a, 0);
    chk("R10 no capture pulse in compare mode", ca, 0);

    do_reset();
    run_for(65540);
    chk("R11 wrap", tmr_cnt, 4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule